// File: doc/BRIEF.md
# Interrupt Source Identifier

This block holds the pending interrupt sources of a message-based bus controller that has a set of message objects (32 by default) and one status source. Each message object raises its source with a one-cycle set pulse. Software takes it down by writing a clear for that object. The status source is raised by a status-event pulse and dropped as a side effect of software reading the controller's status register. The controller signals that read to this block with a one-cycle strobe.

From the registered pending bits, the block forms a 16-bit identifier that names the single most urgent pending source. The status source always wins and is reported with the dedicated code 0x8000. Otherwise the lowest-numbered pending object is reported as its object number. The identifier can be read as a 32-bit read-only word at byte offset 0x10 of a simple register bus. It also drives a level interrupt request, gated by an enable bit.

Top module: `irq_ident_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), nothing is pending, the identifier is 0x0000 and irq is low.
- R2: With bus_rd high and bus_addr equal to 0x10, bus_rdata is {16'h0000, identifier}. For any other address, or with bus_rd low, bus_rdata is zero.
- R3: When only message bit k (0-based) of the pending set is active, the identifier is k+1. This covers the boundaries 0x0001 for bit 0 and 0x0020 for bit 31.
- R4: While the status source is pending, the identifier is 0x8000, whatever message sources are also pending.
- R5: If no status source is pending and several message sources are pending, the identifier is the lowest object number among them, whatever the order in which they were set.
- R6: A pending source stays pending across any number of cycles until its own clear arrives. A clear for another source leaves it pending.
- R7: A msg_clr bit removes that object's pending state. On the next cycle the identifier moves to the next-highest pending source, or to 0x0000 if none is left.
- R8: A stat_rd strobe removes the status source. msg_clr does not affect the status source, and stat_rd does not affect message sources.
- R9: If a set and a clear for the same source arrive in the same cycle, the source is pending afterwards.
- R10: irq is high exactly when the identifier is nonzero and int_en is high. It follows int_en in the same cycle.
- R11: The identifier only ever takes the value 0x0000, a value from 0x0001 up to the object count, or 0x8000.
- R12: A set or clear applied in one cycle shows in the identifier from the next rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_set | input | 32 | One-cycle set pulse per message object; bit k is object k+1 |
| msg_clr | input | 32 | One-cycle clear write per message object; bit k is object k+1 |
| stat_evt | input | 1 | One-cycle status-event pulse |
| stat_rd | input | 1 | Strobe marking a read of the status register |
| int_en | input | 1 | Interrupt-request enable |
| bus_rd | input | 1 | Register read select |
| bus_addr | input | 8 | Register byte address |
| bus_rdata | output | 32 | Read data; the identifier word at 0x10 |
| int_id | output | 16 | Current identifier |
| irq | output | 1 | Level interrupt request |

## Verification
Several rules are checked by assertions on every cycle. The identifier must always hold a legal code, and a pending status source must force 0x8000. Each set must be visible in the next cycle, and each clear without a set must take effect in the next cycle. The request line must match the pending state combined with the enable. Other behaviour depends on history, and only the bench's scenarios can show it. These include the priority among several objects set in reversed order, the move to the next source after a clear, and the R6 persistence over long idle stretches. They also include the bus decode at wrong addresses and the separation between message clears and status-register reads. For these the bench compares against a reference model of the pending state.

// File: rtl/irq_ident_pkg.sv
// Package: shared sizes and codes for the interrupt source identifier.
// Assumes: object numbers fit below the status code.
package irq_ident_pkg;
    localparam int unsigned ID_W        = 16;
    localparam int unsigned BUS_W       = 32;
    localparam int unsigned ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] ID_REG_OFFSET = 8'h10;
    localparam logic [ID_W-1:0]   ID_NONE       = 16'h0000;
    localparam logic [ID_W-1:0]   ID_STATUS     = 16'h8000;
endpackage

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Holds WIDTH independent pending flags. Each flag is raised by its set
// input and dropped by its clear input; set wins when both are active.
// Assumes: synchronous active-low reset, set/clear sampled at rising edge.
module irq_pend_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        // Update one pending flag: reset, then set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end

        AST_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);                            // R9
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]);            // R12
        AST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);            // R6
    end

endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Turns pending flags into one identifier: status first, otherwise the
// lowest-indexed message flag reported as index+1, else zero.
// Assumes: NUM_OBJ + 1 < status code, so codes never collide.
module irq_prio_enc
    import irq_ident_pkg::*;
#(
    parameter int unsigned NUM_OBJ = 32
) (
    input  logic               stat_pend_i,
    input  logic [NUM_OBJ-1:0] msg_pend_i,
    output logic [ID_W-1:0]    id_o
);

    logic [ID_W-1:0] msg_id;

    // Scan from highest index down so the lowest set index is kept last.
    always_comb begin
        msg_id = ID_NONE;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (msg_pend_i[i])
                msg_id = ID_W'(i + 1);
        end
    end

    // Status source overrides any message source.
    always_comb begin
        id_o = stat_pend_i ? ID_STATUS : msg_id;
    end

endmodule

// File: rtl/irq_ident_reg.sv
// Module: irq_ident_reg (top)
// Keeps message and status pending state, reports the most urgent source
// as a 16-bit identifier on a read-only register and drives a level IRQ.
// Assumes: stat_rd pulses once per status-register read; bus reads are
// combinational and side-effect free.
module irq_ident_reg
    import irq_ident_pkg::*;
#(
    parameter int unsigned NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] msg_set,
    input  logic [NUM_OBJ-1:0] msg_clr,
    input  logic               stat_evt,
    input  logic               stat_rd,
    input  logic               int_en,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic [ID_W-1:0]    int_id,
    output logic               irq
);

    localparam int unsigned PAD_W = BUS_W - ID_W;

    logic [NUM_OBJ-1:0] msg_pend;
    logic [0:0]         stat_pend;

    irq_pend_bank #(.WIDTH(NUM_OBJ)) u_msg_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (msg_set),
        .clr_i  (msg_clr),
        .pend_o (msg_pend)
    );

    irq_pend_bank #(.WIDTH(1)) u_stat_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stat_evt),
        .clr_i  (stat_rd),
        .pend_o (stat_pend)
    );

    irq_prio_enc #(.NUM_OBJ(NUM_OBJ)) u_enc (
        .stat_pend_i (stat_pend[0]),
        .msg_pend_i  (msg_pend),
        .id_o        (int_id)
    );

    // Level request: any source reported and requests enabled.
    always_comb begin
        irq = (int_id != ID_NONE) && int_en;
    end

    // Read-only register decode; upper half always zero.
    always_comb begin
        if (bus_rd && (bus_addr == ID_REG_OFFSET))
            bus_rdata = {{PAD_W{1'b0}}, int_id};
        else
            bus_rdata = '0;
    end

    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == ID_NONE) || (int_id == ID_STATUS) ||
        (int_id <= ID_W'(NUM_OBJ)));                            // R11
    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pend[0] |-> (int_id == ID_STATUS));                // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_pend[0] && (msg_pend == '0)) |-> (int_id == ID_NONE)); // R7
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((stat_pend[0] || (msg_pend != '0)) && int_en)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (int_id == ID_NONE) && !irq);                // R1

endmodule

// File: tb/tb_irq_ident_reg.sv
// Bench for irq_ident_reg: directed corners plus seeded random traffic,
// compared each cycle against a pending-state model built from the brief.
module tb_irq_ident_reg;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  msg_set, msg_clr;
    logic          stat_evt, stat_rd, int_en, bus_rd;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_rdata;
    logic [15:0]   int_id;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [N-1:0]  m_pend;
    logic          m_stat;

    always #10 clk = ~clk;   // 50 MHz

    irq_ident_reg #(.NUM_OBJ(N)) dut (
        .clk(clk), .rst_n(rst_n), .msg_set(msg_set), .msg_clr(msg_clr),
        .stat_evt(stat_evt), .stat_rd(stat_rd), .int_en(int_en),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .int_id(int_id), .irq(irq)
    );

    function automatic logic [15:0] exp_id(logic [N-1:0] p, logic s);
        if (s) return 16'h8000;
        for (int i = 0; i < N; i++) if (p[i]) return 16'(i + 1);
        return 16'h0000;
    endfunction

    function automatic logic [31:0] exp_rdata(logic [15:0] id, logic rd,
                                              logic [7:0] a);
        return (rd && a == 8'h10) ? {16'h0, id} : 32'h0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model (called away from the edge).
    task automatic check_all(string req);
        logic [15:0] e;
        e = exp_id(m_pend, m_stat);
        chk(req, {16'h0, int_id}, {16'h0, e});
        chk({req, " R10"}, {31'h0, irq}, {31'h0, (e != 16'h0) && int_en});
        chk({req, " R2"}, bus_rdata, exp_rdata(e, bus_rd, bus_addr));
    endtask

    // Apply one cycle of stimulus, advance the model, check after the edge.
    task automatic step(logic [N-1:0] s, logic [N-1:0] c, logic se,
                        logic sr, string req);
        msg_set = s; msg_clr = c; stat_evt = se; stat_rd = sr;
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0; m_stat = 1'b0;
        end else begin
            m_pend = (m_pend & ~c) | s;
            m_stat = se ? 1'b1 : (sr ? 1'b0 : m_stat);
        end
        @(negedge clk);
        msg_set = '0; msg_clr = '0; stat_evt = 1'b0; stat_rd = 1'b0;
        #1;
        check_all(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd7151;
        void'($urandom(seed));
        rst_n = 1'b0; msg_set = '0; msg_clr = '0; stat_evt = 0; stat_rd = 0;
        int_en = 1'b1; bus_rd = 1'b1; bus_addr = 8'h10;
        m_pend = '0; m_stat = 1'b0;
        // R1: load junk while held in reset; must stay empty
        step('1, '0, 1'b1, 1'b0, "R1");
        step('0, '0, 1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        step('0, '0, 1'b0, 1'b0, "R1");

        // R3 boundaries and a middle object, R12 next-cycle visibility
        step(32'h1 << 5, '0, 0, 0, "R3 R12");
        chk("R3", {16'h0, int_id}, 32'h6);
        step('0, 32'h1 << 5, 0, 0, "R7 R12");
        step(32'h8000_0000, '0, 0, 0, "R3");
        chk("R3", {16'h0, int_id}, 32'h20);
        step(32'h1, '0, 0, 0, "R3 R5");
        chk("R3", {16'h0, int_id}, 32'h1);
        step('0, '0, 0, 0, "R6");
        // R5: set in reversed order, lowest number still wins
        step(32'h0000_0400, '0, 0, 0, "R5");
        step(32'h0000_0008, '0, 0, 0, "R5");
        // R7: peel off sources one by one
        step('0, 32'h1, 0, 0, "R7");
        chk("R7", {16'h0, int_id}, 32'h4);
        step('0, 32'h8, 0, 0, "R7");
        chk("R7", {16'h0, int_id}, 32'hB);
        // R4 status above all; R8 msg_clr leaves status alone
        step('0, '0, 1, 0, "R4");
        chk("R4", {16'h0, int_id}, 32'h8000);
        step('0, '1, 0, 0, "R8");
        chk("R8", {16'h0, int_id}, 32'h8000);
        step(32'h4, '0, 0, 0, "R4");
        step('0, '0, 0, 1, "R8");
        chk("R8", {16'h0, int_id}, 32'h3);
        // R9: set and clear together keep the source pending
        step(32'h4, 32'h4, 1, 1, "R9");
        chk("R9", {16'h0, int_id}, 32'h8000);
        step('0, '0, 0, 1, "R9");
        chk("R9", {16'h0, int_id}, 32'h3);
        // R10: enable low drops irq at once
        int_en = 1'b0; #1; check_all("R10");
        chk("R10", {31'h0, irq}, 32'h0);
        int_en = 1'b1; #1; check_all("R10");
        // R2: other address and no select read zero
        bus_addr = 8'h14; #1; check_all("R2");
        bus_rd = 1'b0; bus_addr = 8'h10; #1; check_all("R2");
        bus_rd = 1'b1;
        step('0, 32'h4, 0, 0, "R7");
        chk("R7", {16'h0, int_id}, 32'h0);

        // Random traffic: R5 R6 R7 R8 R11
        for (int cyc = 0; cyc < 3000; cyc++) begin
            logic [N-1:0] s, c;
            s = $urandom() & $urandom() & $urandom() & $urandom();
            c = $urandom() & $urandom() & $urandom();
            int_en = ($urandom() % 8) != 0;
            bus_rd = ($urandom() % 8) != 0;
            bus_addr = (($urandom() % 6) == 0) ? 8'($urandom()) : 8'h10;
            step(s, c, ($urandom() % 20) == 0, ($urandom() % 10) == 0,
                 "R5 R6 R7 R8 R11");
        end
        finish_run();
    end

endmodule